// File: doc/BRIEF.md
# Byte/Word Selectable Host Bus Adapter

This block connects an asynchronous-style host bus (active-low chip select, read strobe and write strobe) to a synchronous memory array that is sixteen bits wide. A single mode input chooses between an 8-bit host view and a 16-bit host view. In the narrow view, the host moves one byte at a time on its low data lane. The lowest host address bit then picks which half of the array word is meant. In the wide view, all sixteen lanes carry data and the lowest host address bit plays no part.

Writes are captured while the write strobe is active. They are committed to the array as a single strobed cycle once the pulse ends, with per-byte write enables. Reads issue an array read, and then steer the returned word or the selected byte back onto the host lanes. Each lane has its own output enable, so the upper lane can be released in the narrow view. The mode is sampled at the start of every access and held until that access ends.

Top module: `bus_width_adapter`

## Requirements
- R1: With the mode input low (byte view), a write to an even host address commits one array cycle with strobe pattern 2'b01, and host lane bits 7:0 appear in array data bits 7:0.
- R2: In byte view, a write to an odd host address commits with strobe pattern 2'b10, and host lane bits 7:0 appear in array data bits 15:8.
- R3: In byte view, a read returns array bits 7:0 (host address bit 0 = 0) or bits 15:8 (bit 0 = 1) on host data bits 7:0.
- R4: In byte view, the upper lane enable (host_dq_oe_o[1]) stays low during reads, while the lower lane enable (bit 0) is high.
- R5: With the mode input high (word view), the array word address is host address bits ADDR_W-1:1, and host address bit 0 has no effect on reads or writes.
- R6: In word view, writes commit with strobe pattern 2'b11 and all sixteen host bits. Reads drive all sixteen bits, with both lane enables high.
- R7: A lane enable is high only while chip select and read strobe are both low and the write strobe is high.
- R8: Each write pulse (chip select and write strobe both low) produces exactly one array write cycle. That cycle is the clock cycle after the first rising clock edge at which the pulse is seen ended, and its array address is the host address >> 1.
- R9: A change of the mode input during an access does not alter that access. The mode sampled at the first cycle of the access applies throughout.
- R10: While reset is asserted, no array write or read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_mode_i | input | 1 | 1 = word view, 0 = byte view |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Read strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| host_addr_i | input | ADDR_W | Host byte address |
| host_dq_i | input | 2*LANE_W | Host write data |
| host_dq_o | output | 2*LANE_W | Host read data |
| host_dq_oe_o | output | 2 | Per-lane output enable (bit 1 = upper lane) |
| arr_addr_o | output | ADDR_W-1 | Array word address |
| arr_wdata_o | output | 2*LANE_W | Array write data |
| arr_be_o | output | 2 | Array byte write strobes |
| arr_we_o | output | 1 | Array write cycle |
| arr_re_o | output | 1 | Array read cycle |
| arr_rdata_i | input | 2*LANE_W | Array read data, one cycle after arr_re_o |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe pattern of every committed write matches its sampled mode;
- one commit follows each write pulse;
- no lane enable rises outside a read;
- the upper lane stays released in the byte view;
- the upper lane enable stays fixed for the whole of an ongoing read.

Other properties need the bench scenarios. These are lane steering of data in both directions, the address bit 0 being ignored in the word view, and read-back of mixed byte and word writes against a reference image. They also include accesses whose mode input flips midway.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  typedef enum logic {MODE_BYTE = 1'b0, MODE_WORD = 1'b1} bus_mode_e;
  localparam int unsigned LANES = 2;
endpackage

// File: rtl/bwa_addr_map.sv
module bwa_addr_map
  import bwa_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  bus_mode_e         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-2:0] word_o,
  output logic              hi_sel_o
);
  assign word_o   = addr_i[ADDR_W-1:1];
  // bit 0 only matters in byte view
  assign hi_sel_o = (mode_i == MODE_BYTE) && addr_i[0];
endmodule

// File: rtl/bwa_write_ctl.sv
module bwa_write_ctl
  import bwa_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  bus_mode_e               mode_i,
  input  logic                    ce_ni,
  input  logic                    we_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic                    arr_we_o,
  output logic [ADDR_W-2:0]       arr_addr_o,
  output logic [LANES*LANE_W-1:0] arr_wdata_o,
  output logic [LANES-1:0]        arr_be_o
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic              wr_active, act_q;
  bus_mode_e         mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, steer_d;
  logic [LANES-1:0]  be_d;
  logic [ADDR_W-2:0] word_d;
  logic              hi_sel_d;
  logic              commit_d;

  assign wr_active = !ce_ni && !we_ni;
  assign commit_d  = act_q && !wr_active;

  bwa_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .mode_i  (mode_q),
    .addr_i  (addr_q),
    .word_o  (word_d),
    .hi_sel_o(hi_sel_d)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign steer_d[l*LANE_W +: LANE_W] = (mode_q == MODE_WORD) ? data_q[l*LANE_W +: LANE_W]
                                                                : data_q[LANE_W-1:0];
    assign be_d[l] = (mode_q == MODE_WORD) || (hi_sel_d == 1'(l));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      mode_q      <= MODE_BYTE;
      addr_q      <= '0;
      data_q      <= '0;
      arr_we_o    <= 1'b0;
      arr_addr_o  <= '0;
      arr_wdata_o <= '0;
      arr_be_o    <= '0;
    end else begin
      act_q    <= wr_active;
      arr_we_o <= commit_d;
      // mode frozen at first cycle of the pulse
      if (wr_active && !act_q) mode_q <= mode_i;
      if (wr_active) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
      if (commit_d) begin
        arr_addr_o  <= word_d;
        arr_wdata_o <= steer_d;
        arr_be_o    <= be_d;
      end
    end
  end

  AST_BYTE_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && mode_q == MODE_BYTE) |-> $countones(arr_be_o) == 1); // R1
  AST_WORD_ALL_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_we_o && mode_q == MODE_WORD) |-> arr_be_o == '1); // R6
  AST_COMMIT_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |-> ($past(wr_active, 2) && !$past(wr_active))); // R8
  AST_COMMIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_we_o |=> !arr_we_o); // R8
endmodule

// File: rtl/bwa_read_ctl.sv
module bwa_read_ctl
  import bwa_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  bus_mode_e               mode_i,
  input  logic                    ce_ni,
  input  logic                    oe_ni,
  input  logic                    we_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] arr_rdata_i,
  output logic                    arr_re_o,
  output logic [ADDR_W-2:0]       arr_addr_o,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic [LANES-1:0]        dq_oe_o
);
  logic              rd_active, act_q;
  bus_mode_e         mode_q, eff_mode, mode_d_q;
  logic [ADDR_W-2:0] word_d;
  logic              hi_sel_d, sel_q, sel_d_q;

  assign rd_active = !ce_ni && !oe_ni && we_ni;
  assign eff_mode  = act_q ? mode_q : mode_i;

  bwa_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .mode_i  (eff_mode),
    .addr_i  (addr_i),
    .word_o  (word_d),
    .hi_sel_o(hi_sel_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      mode_q     <= MODE_BYTE;
      arr_addr_o <= '0;
      sel_q      <= 1'b0;
      sel_d_q    <= 1'b0;
      mode_d_q   <= MODE_BYTE;
    end else begin
      act_q    <= rd_active;
      sel_d_q  <= sel_q;
      mode_d_q <= mode_q;
      if (rd_active) begin
        mode_q     <= eff_mode;
        arr_addr_o <= word_d;
        sel_q      <= hi_sel_d;
      end
    end
  end

  assign arr_re_o = act_q;

  // align steering with the array's one-cycle read latency
  always_comb begin
    if (mode_d_q == MODE_WORD) begin
      dq_o = arr_rdata_i;
    end else begin
      dq_o = '0;
      dq_o[LANE_W-1:0] = sel_d_q ? arr_rdata_i[2*LANE_W-1:LANE_W] : arr_rdata_i[LANE_W-1:0];
    end
  end

  assign dq_oe_o[0] = rd_active;
  assign dq_oe_o[1] = rd_active && (eff_mode == MODE_WORD);

  AST_UPPER_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && mode_q == MODE_BYTE) |-> !dq_oe_o[1]); // R4
  AST_UPPER_ENABLE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_active && act_q) |-> $stable(dq_oe_o[1])); // R9
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wide_mode_i,
  input  logic                    ce_ni,
  input  logic                    oe_ni,
  input  logic                    we_ni,
  input  logic [ADDR_W-1:0]       host_addr_i,
  input  logic [2*LANE_W-1:0]     host_dq_i,
  output logic [2*LANE_W-1:0]     host_dq_o,
  output logic [1:0]              host_dq_oe_o,
  output logic [ADDR_W-2:0]       arr_addr_o,
  output logic [2*LANE_W-1:0]     arr_wdata_o,
  output logic [1:0]              arr_be_o,
  output logic                    arr_we_o,
  output logic                    arr_re_o,
  input  logic [2*LANE_W-1:0]     arr_rdata_i
);
  bus_mode_e         mode;
  logic [ADDR_W-2:0] wr_addr, rd_addr;

  assign mode = bus_mode_e'(wide_mode_i);

  bwa_write_ctl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .ce_ni      (ce_ni),
    .we_ni      (we_ni),
    .addr_i     (host_addr_i),
    .data_i     (host_dq_i),
    .arr_we_o   (arr_we_o),
    .arr_addr_o (wr_addr),
    .arr_wdata_o(arr_wdata_o),
    .arr_be_o   (arr_be_o)
  );

  bwa_read_ctl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .addr_i     (host_addr_i),
    .arr_rdata_i(arr_rdata_i),
    .arr_re_o   (arr_re_o),
    .arr_addr_o (rd_addr),
    .dq_o       (host_dq_o),
    .dq_oe_o    (host_dq_oe_o)
  );

  assign arr_addr_o = arr_we_o ? wr_addr : rd_addr;

  AST_OE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|host_dq_oe_o) |-> (!ce_ni && !oe_ni && we_ni)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (!arr_we_o && !arr_re_o)); // R10
endmodule

// File: tb/bus_width_adapter_test.sv
`timescale 1ns/1ps
module bus_width_adapter_test;
  localparam int ADDR_W = 8;
  localparam int WORDS  = 1 << (ADDR_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out, arr_wdata, arr_rdata = '0;
  logic [1:0]  dq_oe, arr_be;
  logic [ADDR_W-2:0] arr_addr;
  logic arr_we, arr_re;

  logic [15:0] mem [WORDS];
  logic [15:0] ref_mem [WORDS];
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_width_adapter #(.ADDR_W(ADDR_W), .LANE_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wide_mode_i(wide), .ce_ni(ce_n), .oe_ni(oe_n),
    .we_ni(we_n), .host_addr_i(addr), .host_dq_i(dq_in), .host_dq_o(dq_out),
    .host_dq_oe_o(dq_oe), .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata),
    .arr_be_o(arr_be), .arr_we_o(arr_we), .arr_re_o(arr_re), .arr_rdata_i(arr_rdata)
  );

  // array model: byte-strobed write, one-cycle read
  always @(posedge clk) begin
    if (arr_we) begin
      if (arr_be[0]) mem[arr_addr][7:0]  <= arr_wdata[7:0];
      if (arr_be[1]) mem[arr_addr][15:8] <= arr_wdata[15:8];
    end
    if (arr_re) arr_rdata <= mem[arr_addr];
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_be(bit w, bit a0);
    return w ? 2'b11 : (a0 ? 2'b10 : 2'b01);
  endfunction

  function automatic logic [15:0] exp_read(bit w, logic [ADDR_W-1:0] a);
    logic [15:0] v = ref_mem[a[ADDR_W-1:1]];
    if (w) return v;
    return {8'h00, a[0] ? v[15:8] : v[7:0]};
  endfunction

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic do_write(bit w, logic [ADDR_W-1:0] a, logic [15:0] d, bit flip, string req);
    logic [15:0] mask;
    logic [1:0]  be;
    @(negedge clk);
    wide = w; addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    if (flip) wide = ~w;
    @(negedge clk);
    idle();
    @(negedge clk);
    be   = exp_be(w, a[0]);
    mask = {{8{be[1]}}, {8{be[0]}}};
    check(arr_we == 1'b1, req, 32'(arr_we), 32'd1);
    check(arr_be == be, req, 32'(arr_be), 32'(be));
    check(arr_addr == a[ADDR_W-1:1], req, 32'(arr_addr), 32'(a[ADDR_W-1:1]));
    if (w) begin
      check(arr_wdata == d, req, 32'(arr_wdata), 32'(d));
      ref_mem[a[ADDR_W-1:1]] = d;
    end else if (a[0]) begin
      check((arr_wdata & mask) == {d[7:0], 8'h00}, req, 32'(arr_wdata & mask), 32'({d[7:0], 8'h00}));
      ref_mem[a[ADDR_W-1:1]][15:8] = d[7:0];
    end else begin
      check((arr_wdata & mask) == {8'h00, d[7:0]}, req, 32'(arr_wdata & mask), 32'({8'h00, d[7:0]}));
      ref_mem[a[ADDR_W-1:1]][7:0] = d[7:0];
    end
    @(negedge clk);
    check(arr_we == 1'b0, "R8", 32'(arr_we), 32'd0);
  endtask

  task automatic do_read(bit w, logic [ADDR_W-1:0] a, bit flip, string req);
    logic [15:0] e;
    @(negedge clk);
    wide = w; addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    if (flip) wide = ~w;
    repeat (3) @(negedge clk);
    e = exp_read(w, a);
    check(dq_oe == (w ? 2'b11 : 2'b01), w ? "R6" : "R4", 32'(dq_oe), w ? 32'd3 : 32'd1);
    if (w) check(dq_out == e, req, 32'(dq_out), 32'(e));
    else   check(dq_out[7:0] == e[7:0], req, 32'(dq_out[7:0]), 32'(e[7:0]));
    idle();
    @(negedge clk);
    check(dq_oe == 2'b00, "R7", 32'(dq_oe), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = '0;
      ref_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check(arr_we == 1'b0, "R10", 32'(arr_we), 32'd0);
    check(arr_re == 1'b0, "R10", 32'(arr_re), 32'd0);
    check(dq_oe == 2'b00, "R10", 32'(dq_oe), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_write(1'b1, 8'h10, 16'hA55A, 1'b0, "R6");
    do_read (1'b0, 8'h10, 1'b0, "R3");
    do_read (1'b0, 8'h11, 1'b0, "R3");
    do_write(1'b0, 8'h11, 16'hFF3C, 1'b0, "R2");
    do_read (1'b1, 8'h10, 1'b0, "R2");
    do_write(1'b0, 8'h10, 16'hEEC3, 1'b0, "R1");
    do_read (1'b1, 8'h11, 1'b0, "R5");
    do_write(1'b1, 8'h21, 16'h1234, 1'b0, "R5");
    do_read (1'b1, 8'h20, 1'b0, "R5");
    do_read (1'b0, 8'h21, 1'b0, "R3");
    // R9: mode flips mid-access
    do_write(1'b0, 8'h31, 16'h0077, 1'b1, "R9");
    do_read (1'b1, 8'h30, 1'b0, "R9");
    do_read (1'b0, 8'h31, 1'b1, "R9");
    do_write(1'b1, 8'h40, 16'hBEEF, 1'b1, "R9");
    do_read (1'b1, 8'h40, 1'b1, "R9");

    // R7: no enable without a proper read
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    check(dq_oe == 2'b00, "R7", 32'(dq_oe), 32'd0);
    ce_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    check(dq_oe == 2'b00, "R7", 32'(dq_oe), 32'd0);
    idle();

    void'($urandom(32'd4711));
    for (int n = 0; n < 300; n++) begin
      bit w = 1'($urandom);
      logic [ADDR_W-1:0] a = ADDR_W'($urandom);
      if ($urandom % 2) do_write(w, a, 16'($urandom), 1'($urandom % 4 == 0), w ? "R6" : (a[0] ? "R2" : "R1"));
      else              do_read (w, a, 1'($urandom % 4 == 0), w ? "R6" : "R3");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule